// File: doc/BRIEF.md
# Transactional Line Conflict Tracker

This block records which cache lines the running hardware transaction has touched. It is a fully associative table of line addresses, and each entry carries a read mark and a write mark. Local transactional loads and stores allocate entries or update the marks of entries already present. Accesses snooped from other agents are compared against every entry at once. When a snooped access hits a tracked line and either side of the pair is a store, the transaction is aborted.

The table holds a fixed number of lines. A local access that needs a new line while every entry is in use ends the transaction with a capacity abort. Each abort comes out as a one-cycle pulse carrying a reason code and a flag that says whether retrying is likely to help.

A transaction can be started in rollback-only mode. In that mode the table still counts lines against capacity, but snoop hits never raise a conflict. Storing the speculative data is outside this block.

Top module: `txn_line_tracker`

## Requirements
- R1: With the default 64 entries, 64 distinct lines can be accessed without an abort. The next distinct line aborts with reason 1 (capacity) and the persistent flag set to 1.
- R2: Tracking is by 128-byte line, meaning address bits [31:7]. Different byte offsets within one line map to the same entry and can conflict with each other. Addresses in neighbouring lines never match.
- R3: A valid snoop that hits a tracked line aborts the transaction when the snoop is a store, or when the tracked line has its write mark set. A load snoop to a line that was only read does not abort, and neither does a snoop that misses the table.
- R4: A conflict abort reports reason 2 when the snoop is transactional and reason 3 when it is not. In both cases the persistent flag is 0.
- R5: A repeated access to a line already tracked only sets its read or write mark and uses no new entry. This still works when the table is full, and a store that follows a load on the same line makes later load snoops conflict.
- R6: When rollback_only is high at transaction begin, the mode is held for the whole transaction. In that mode no snoop ever aborts, but capacity is still counted and overflow still aborts with reason 1.
- R7: Commit or an abort command clears every entry in one cycle and lowers busy from the next cycle. Neither raises abort_pulse.
- R8: abort_pulse is high for exactly one cycle, starting in the cycle after the access that caused it. In that same cycle busy is low and the table is empty. reason is 0 when no pulse is present.
- R9: When a snoop and a local access arrive in the same cycle, the snoop is evaluated first. A snoop conflict is reported as a conflict even if the local access would have overflowed the table, and the local access is dropped.
- R10: After reset, and whenever no transaction is running, busy is low and local accesses and snoops have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_begin | input | 1 | Start a transaction and clear the table |
| txn_commit | input | 1 | End the transaction successfully and clear the table |
| txn_abort_cmd | input | 1 | Software-requested abort; clears the table without a pulse |
| rollback_only | input | 1 | Mode for the transaction, sampled when txn_begin is high |
| acc_valid | input | 1 | Local transactional access |
| acc_is_store | input | 1 | Local access is a store |
| acc_addr | input | ADDR_W | Byte address of the local access |
| snp_valid | input | 1 | Snooped remote access |
| snp_is_store | input | 1 | Snoop is a store |
| snp_is_txn | input | 1 | Snoop comes from a transactional access |
| snp_addr | input | ADDR_W | Byte address of the snoop |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_reason | output | 2 | 1 capacity, 2 transactional conflict, 3 non-transactional conflict, 0 none |
| abort_persistent | output | 1 | High when the abort is expected to recur on retry |
| busy | output | 1 | A transaction is running |

## Verification
The bench fills the table to the last entry and then offers one more line. A design with an off-by-one in the full test would either abort one line early or let the sixty-fifth line through. The bench sweeps every pairing of local load or store against snooped load or store, from both transactional and non-transactional sources. A wrong conflict rule would show up as a missed or spurious pulse, and a swapped reason code as the wrong value. Offsets at the two edges of a line check that a design comparing too many or too few address bits is caught. The remaining tests cover a snoop colliding with an overflowing access in the same cycle, a store upgrading a read-only line while the table is full, and rollback-only transactions. Each of these exposes a design that gives the wrong priority, allocates a duplicate entry, or keeps checking conflicts in the quiet mode.

// File: rtl/txn_line_tracker.sv
module txn_line_tracker #(
  parameter int ENTRIES   = 64,
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_begin,
  input  logic              txn_commit,
  input  logic              txn_abort_cmd,
  input  logic              rollback_only,
  input  logic              acc_valid,
  input  logic              acc_is_store,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              snp_valid,
  input  logic              snp_is_store,
  input  logic              snp_is_txn,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              abort_pulse,
  output logic [1:0]        abort_reason,
  output logic              abort_persistent,
  output logic              busy
);
  localparam int TAG_W = ADDR_W - LINE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, rd_q, wr_q;
  logic               active_q, rb_q;
  logic               abort_q, pers_q;
  logic [1:0]         reason_q;

  logic [TAG_W-1:0]   acc_tag, snp_tag;
  logic [ENTRIES-1:0] acc_hit, snp_hit;
  logic [IDX_W-1:0]   free_idx;
  logic               conflict, overflow, alloc, full;

  assign acc_tag = acc_addr[ADDR_W-1:LINE_BITS];
  assign snp_tag = snp_addr[ADDR_W-1:LINE_BITS];

  always_comb begin
    acc_hit  = '0;
    snp_hit  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      acc_hit[i] = vld_q[i] && (tag_q[i] == acc_tag);
      snp_hit[i] = vld_q[i] && (tag_q[i] == snp_tag);
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign full     = &vld_q;
  assign conflict = active_q && snp_valid && !rb_q &&
                    |(snp_hit & (wr_q | {ENTRIES{snp_is_store}}));
  assign overflow = active_q && acc_valid && !conflict && !(|acc_hit) && full;
  assign alloc    = active_q && acc_valid && !conflict && !(|acc_hit) && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      rd_q     <= '0;
      wr_q     <= '0;
      active_q <= 1'b0;
      rb_q     <= 1'b0;
      abort_q  <= 1'b0;
      reason_q <= 2'd0;
      pers_q   <= 1'b0;
    end else begin
      abort_q  <= 1'b0;
      reason_q <= 2'd0;
      pers_q   <= 1'b0;
      if (txn_commit || txn_abort_cmd) begin
        vld_q    <= '0;
        active_q <= 1'b0;
      end else if (txn_begin) begin
        vld_q    <= '0;
        active_q <= 1'b1;
        rb_q     <= rollback_only;
      end else if (conflict || overflow) begin
        vld_q    <= '0;
        active_q <= 1'b0;
        abort_q  <= 1'b1;
        reason_q <= overflow ? 2'd1 : (snp_is_txn ? 2'd2 : 2'd3);
        pers_q   <= overflow;
      end else if (active_q && acc_valid) begin
        if (alloc) begin
          vld_q[free_idx] <= 1'b1;
          rd_q[free_idx]  <= !acc_is_store;
          wr_q[free_idx]  <= acc_is_store;
        end else begin
          rd_q <= rd_q | (acc_hit & {ENTRIES{!acc_is_store}});
          wr_q <= wr_q | (acc_hit & {ENTRIES{acc_is_store}});
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) tag_q[free_idx] <= acc_tag;
  end

  assign abort_pulse      = abort_q;
  assign abort_reason     = reason_q;
  assign abort_persistent = pers_q;
  assign busy             = active_q;
endmodule

// File: rtl/txn_line_tracker_chk.sv
module txn_line_tracker_chk #(
  parameter int ENTRIES = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               txn_begin,
  input logic               txn_commit,
  input logic               txn_abort_cmd,
  input logic               abort_pulse,
  input logic [1:0]         abort_reason,
  input logic               abort_persistent,
  input logic               busy,
  input logic               rb_q,
  input logic [ENTRIES-1:0] vld_q
);
  a_r4_persist_only_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (abort_persistent == (abort_reason == 2'd1)));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);

  a_r8_pulse_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (!busy && vld_q == '0));

  a_r6_quiet_mode_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && rb_q) |-> abort_reason == 2'd1);

  a_r7_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_commit || txn_abort_cmd) |=> (vld_q == '0 && !busy && !abort_pulse));

  a_r10_idle_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !abort_pulse);

  a_r8_reason_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> abort_reason != 2'd0);

  a_r10_begin_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_begin && !txn_commit && !txn_abort_cmd) |=> busy);
endmodule

bind txn_line_tracker txn_line_tracker_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .txn_begin(txn_begin), .txn_commit(txn_commit),
  .txn_abort_cmd(txn_abort_cmd), .abort_pulse(abort_pulse),
  .abort_reason(abort_reason), .abort_persistent(abort_persistent),
  .busy(busy), .rb_q(rb_q), .vld_q(vld_q)
);

// File: tb/txn_line_tracker_tb_top.sv
module txn_line_tracker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_begin = 0, txn_commit = 0, txn_abort_cmd = 0, rollback_only = 0;
  logic acc_valid = 0, acc_is_store = 0, snp_valid = 0, snp_is_store = 0, snp_is_txn = 0;
  logic [31:0] acc_addr = '0, snp_addr = '0;
  logic abort_pulse, abort_persistent, busy;
  logic [1:0] abort_reason;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  txn_line_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .txn_begin(txn_begin), .txn_commit(txn_commit),
    .txn_abort_cmd(txn_abort_cmd), .rollback_only(rollback_only),
    .acc_valid(acc_valid), .acc_is_store(acc_is_store), .acc_addr(acc_addr),
    .snp_valid(snp_valid), .snp_is_store(snp_is_store), .snp_is_txn(snp_is_txn),
    .snp_addr(snp_addr), .abort_pulse(abort_pulse), .abort_reason(abort_reason),
    .abort_persistent(abort_persistent), .busy(busy)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input int p, input int r, input int s, input int b, input string req);
    chk({28'd0, abort_pulse, abort_reason, abort_persistent}, (p << 3) | (r << 1) | s, {req, " pulse/reason/persist"});
    chk(int'(busy), b, {req, " busy"});
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start(input logic rb);
    txn_begin = 1; rollback_only = rb; cyc(); txn_begin = 0; rollback_only = 0;
  endtask

  task automatic finish_txn();
    txn_commit = 1; cyc(); txn_commit = 0;
  endtask

  task automatic access(input logic [31:0] a, input logic st);
    acc_valid = 1; acc_addr = a; acc_is_store = st; cyc(); acc_valid = 0;
  endtask

  task automatic snoop(input logic [31:0] a, input logic st, input logic tx);
    snp_valid = 1; snp_addr = a; snp_is_store = st; snp_is_txn = tx; cyc(); snp_valid = 0;
  endtask

  task automatic fill(input int n, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      access(32'(i) << 7, 1'b0);
      if (abort_pulse) bad++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    @(negedge clk); @(negedge clk);
    chk_out(0, 0, 0, 0, "R10 reset");
    rst_n = 1; cyc();
    // R10: idle accesses and snoops have no effect
    access(32'h100, 1); snoop(32'h100, 1, 1);
    chk_out(0, 0, 0, 0, "R10 idle");

    // R1: capacity boundary
    start(0);
    chk_out(0, 0, 0, 1, "R10 begin");
    fill(64, bad);
    chk(bad, 0, "R1 64 lines fit");
    access(32'd64 << 7, 1'b0);
    chk_out(1, 1, 1, 0, "R1 overflow");
    cyc();
    chk_out(0, 0, 0, 0, "R8 pulse one cycle");
    snoop(32'd3 << 7, 1, 1);
    chk_out(0, 0, 0, 0, "R8 table cleared after abort");

    // R5: full table, repeated access then store upgrade
    start(0);
    fill(64, bad);
    access(32'h0000_0010, 1'b0);
    chk_out(0, 0, 0, 1, "R5 hit when full no new entry");
    snoop(32'd5 << 7, 0, 1);
    chk_out(0, 0, 0, 1, "R3 load snoop on read line");
    access(32'd5 << 7, 1'b1);
    chk_out(0, 0, 0, 1, "R5 store upgrade when full");
    snoop(32'd5 << 7 | 32'h40, 0, 0);
    chk_out(1, 3, 0, 0, "R5 write mark conflicts");

    // R3 R4: conflict matrix
    for (int m = 0; m < 8; m++) begin
      logic lst, sst, stx;
      int e;
      lst = m[2]; sst = m[1]; stx = m[0];
      e = (lst || sst) ? 1 : 0;
      start(0);
      access(32'h0000_2A00, lst);
      snoop(32'h0000_3A00, 1, stx);
      chk_out(0, 0, 0, 1, "R3 miss no conflict");
      snoop(32'h0000_2A44, sst, stx);
      chk_out(e, e ? (stx ? 2 : 3) : 0, 0, e ? 0 : 1, "R3 R4 matrix");
      if (busy) finish_txn();
    end

    // R2: line granularity edges
    start(0);
    access(32'h0000_1005, 0);
    snoop(32'h0000_1080, 1, 1);
    chk_out(0, 0, 0, 1, "R2 next line no match");
    snoop(32'h0000_0FFF, 1, 1);
    chk_out(0, 0, 0, 1, "R2 previous line no match");
    snoop(32'h0000_107F, 1, 1);
    chk_out(1, 2, 0, 0, "R2 same line other byte");

    // R6: rollback-only
    start(1);
    access(32'h0, 1);
    snoop(32'h0, 1, 1);
    chk_out(0, 0, 0, 1, "R6 snoop ignored");
    finish_txn();
    start(1);
    fill(64, bad);
    snoop(32'd9 << 7, 1, 0);
    chk(bad + int'(abort_pulse), 0, "R6 fill and snoop");
    access(32'd70 << 7, 0);
    chk_out(1, 1, 1, 0, "R6 overflow counted");

    // R7: commit and abort command
    start(0);
    access(32'h0000_7000, 1);
    finish_txn();
    chk_out(0, 0, 0, 0, "R7 commit");
    start(0);
    snoop(32'h0000_7000, 1, 1);
    chk_out(0, 0, 0, 1, "R7 commit cleared table");
    access(32'h0000_7000, 1);
    txn_abort_cmd = 1; cyc(); txn_abort_cmd = 0;
    chk_out(0, 0, 0, 0, "R7 abort command");

    // R9: snoop before local access
    start(0);
    fill(64, bad);
    snp_valid = 1; snp_addr = 32'd3 << 7; snp_is_store = 1; snp_is_txn = 1;
    acc_valid = 1; acc_addr = 32'd99 << 7; acc_is_store = 0;
    cyc();
    snp_valid = 0; acc_valid = 0;
    chk_out(1, 2, 0, 0, "R9 snoop wins over overflow");
    start(0);
    snp_valid = 1; snp_addr = 32'h0000_5000; snp_is_store = 1; snp_is_txn = 0;
    acc_valid = 1; acc_addr = 32'h0000_5000; acc_is_store = 0;
    cyc();
    snp_valid = 0; acc_valid = 0;
    chk_out(0, 0, 0, 1, "R9 snoop sees table before allocation");
    snoop(32'h0000_5000, 1, 0);
    chk_out(1, 3, 0, 0, "R9 access allocated afterwards");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule